// File: doc/BRIEF.md
# PMP Configuration Register File

This block stores the protection settings for a small set of memory protection entries: one configuration byte per entry, one address word per entry, and a three-bit machine security register. Software reaches all three through a single write port and a combinational read port. A write to a configuration register carries one byte for each of several neighbouring entries. A write to an address register carries one full word for one entry.

The block enforces the lock rules. A locked entry keeps its configuration byte and its address. The address just below a locked top-of-range entry is also frozen. Two security bits become sticky once they are set, provided the enhanced mode input is high.

Whenever stored state really changes, the block raises a one-cycle `rules_changed` pulse. It also raises a per-entry mask that tells a downstream bounds decoder which entries need their bounds worked out again. Every configuration byte and address word is exported as a flat vector for a separate access checker.

Top module: `pmp_cfg_regfile`

## Requirements
- R1: After reset, every configuration byte, every address word, the security register, `rules_changed` and `upd_mask` are zero.
- R2: A write with `wr_sel`=0 places byte b of `wr_data` (bits 8b+7..8b) into entry `wr_idx`*4+b. Bytes that target entries at or beyond `N_ENT` are dropped. With no write, no stored value changes.
- R3: A configuration byte whose lock bit (bit 7) is set is never changed by a configuration write. Other bytes in the same write are still applied.
- R4: A configuration byte equal to the stored one is not counted as a modification.
- R5: `rules_changed` is high for exactly the one cycle after a write that modified stored state, and low otherwise. `upd_mask` marks in that same cycle the entries whose bounds are affected.
- R6: An address write (`wr_sel`=1) to entry n is refused while entry n is locked.
- R7: An address write to entry n is refused while entry n+1 is locked and its mode field (bits 4:3) equals 1, which means top-of-range.
- R8: An accepted address write that changes the value marks entry n, and also marks entry n+1 when that entry is in top-of-range mode. A write of an equal value, or a write to an index at or beyond `N_ENT`, changes nothing.
- R9: With `ext_en`=1, a security write (`wr_sel`=2) cannot clear bit 0 or bit 1 once either is set. Bit 2 follows the written value. The pulse fires only when bit 0 or bit 1 changes, and `upd_mask` stays zero.
- R10: With `ext_en`=0, a security write stores zero in bits 2..0 and raises no pulse.
- R11: The read port returns, in the same cycle, the four configuration bytes of register `rd_idx` (`rd_sel`=0), the address word of entry `rd_idx` (`rd_sel`=1), or the security bits (`rd_sel`=2). Missing entries and `rd_sel`=3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Enhanced protection mode enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 address, 2 security |
| wr_idx | input | IDX_W | Config register or address entry index |
| wr_data | input | XLEN | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | XLEN | Read data |
| cfg_out | output | N_ENT*8 | All configuration bytes, entry e at bits 8e+7..8e |
| addr_out | output | N_ENT*XLEN | All address words, entry e at word e |
| sec_out | output | 3 | Security bits |
| rules_changed | output | 1 | One-cycle pulse after a real state change |
| upd_mask | output | N_ENT | Entries whose bounds need recomputing |

## Verification
The lock filter and change detection can both act on different bytes of the same configuration write. To exercise this, one write targets a locked byte with a new value, an unlocked byte with its old value, and two unlocked bytes with new values. Only the last two may appear in `upd_mask`, and the stored bytes are then read back. A second case of this kind is an address write whose acceptance depends on the neighbouring entry's lock and mode. That case is provoked by locking the neighbour in top-of-range mode, and it is judged by a missing pulse and an unchanged readback.

// File: rtl/pmp_cfg_regfile.sv
module pmp_cfg_regfile #(
  parameter int N_ENT = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ext_en,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [XLEN-1:0]         wr_data,
  input  logic [1:0]              rd_sel,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [XLEN-1:0]         rd_data,
  output logic [N_ENT*8-1:0]      cfg_out,
  output logic [N_ENT*XLEN-1:0]   addr_out,
  output logic [2:0]              sec_out,
  output logic                    rules_changed,
  output logic [N_ENT-1:0]        upd_mask
);
  localparam int BPR = XLEN / 8;
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_SEC  = 2'd2;
  localparam logic [1:0] A_TOR    = 2'd1;

  logic [7:0]      cfg_q  [N_ENT];
  logic [7:0]      cfg_d  [N_ENT];
  logic [XLEN-1:0] addr_q [N_ENT];
  logic [XLEN-1:0] addr_d [N_ENT];
  logic [2:0]      sec_q, sec_d;
  logic [N_ENT:0]  tor_v, lktor_v, mask_d;
  logic [N_ENT-1:0] mask_q;
  logic            sec_chg, chg_q;

  wire wr_cfg  = wr_en && (wr_sel == SEL_CFG);
  wire wr_addr = wr_en && (wr_sel == SEL_ADDR);
  wire wr_sec  = wr_en && (wr_sel == SEL_SEC);

  always_comb begin
    tor_v   = '0;
    lktor_v = '0;
    for (int e = 0; e < N_ENT; e++) begin
      tor_v[e]   = (cfg_q[e][4:3] == A_TOR);
      lktor_v[e] = tor_v[e] && cfg_q[e][7];
    end
  end

  always_comb begin
    cfg_d   = cfg_q;
    addr_d  = addr_q;
    sec_d   = sec_q;
    mask_d  = '0;
    sec_chg = 1'b0;
    for (int e = 0; e < N_ENT; e++) begin
      if (wr_cfg && int'(wr_idx) == e / BPR && !cfg_q[e][7] &&
          wr_data[(e % BPR)*8 +: 8] != cfg_q[e]) begin
        cfg_d[e]  = wr_data[(e % BPR)*8 +: 8];
        mask_d[e] = 1'b1;
      end
      if (wr_addr && int'(wr_idx) == e && !cfg_q[e][7] && !lktor_v[e+1] &&
          wr_data != addr_q[e]) begin
        addr_d[e]   = wr_data;
        mask_d[e]   = 1'b1;
        mask_d[e+1] = mask_d[e+1] | tor_v[e+1];
      end
    end
    if (wr_sec) begin
      if (ext_en) begin
        sec_d   = {wr_data[2], wr_data[1:0] | sec_q[1:0]};
        sec_chg = (sec_d[1:0] != sec_q[1:0]);
      end else begin
        sec_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) begin
        cfg_q[e]  <= '0;
        addr_q[e] <= '0;
      end
      sec_q  <= '0;
      chg_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
      sec_q  <= sec_d;
      chg_q  <= (|mask_d) | sec_chg;
      mask_q <= mask_d[N_ENT-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CFG:
        for (int e = 0; e < N_ENT; e++)
          if (int'(rd_idx) == e / BPR) rd_data[(e % BPR)*8 +: 8] = cfg_q[e];
      SEL_ADDR:
        for (int e = 0; e < N_ENT; e++)
          if (int'(rd_idx) == e) rd_data = addr_q[e];
      SEL_SEC: rd_data[2:0] = sec_q;
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_out
    assign cfg_out[g*8 +: 8]        = cfg_q[g];
    assign addr_out[g*XLEN +: XLEN] = addr_q[g];
  end

  assign sec_out       = sec_q;
  assign rules_changed = chg_q;
  assign upd_mask      = mask_q;
endmodule

// File: rtl/pmp_cfg_regfile_chk.sv
module pmp_cfg_regfile_chk #(
  parameter int N_ENT = 16,
  parameter int XLEN  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ext_en,
  input logic                  wr_en,
  input logic [1:0]            wr_sel,
  input logic [N_ENT*8-1:0]    cfg_out,
  input logic [N_ENT*XLEN-1:0] addr_out,
  input logic [2:0]            sec_out,
  input logic                  rules_changed,
  input logic [N_ENT-1:0]      upd_mask
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out[e*8+7] |=> $stable(cfg_out[e*8 +: 8])); // R3
    AST_ADDR_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out[e*8+7] |=> $stable(addr_out[e*XLEN +: XLEN])); // R6
    if (e + 1 < N_ENT) begin : g_nx
      AST_ADDR_TOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out[(e+1)*8+7] && cfg_out[(e+1)*8+3 +: 2] == 2'd1)
        |=> $stable(addr_out[e*XLEN +: XLEN])); // R7
    end
  end

  AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !rules_changed); // R5
  AST_MASK_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_mask) |-> rules_changed); // R5
  AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cfg_out) && $stable(addr_out) && $stable(sec_out))); // R2
  AST_STICKY_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_out[0] && !(wr_en && wr_sel == 2'd2 && !ext_en)) |=> sec_out[0]); // R9
  AST_STICKY_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_out[1] && !(wr_en && wr_sel == 2'd2 && !ext_en)) |=> sec_out[1]); // R9
endmodule

bind pmp_cfg_regfile pmp_cfg_regfile_chk #(.N_ENT(N_ENT), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .cfg_out(cfg_out), .addr_out(addr_out), .sec_out(sec_out),
  .rules_changed(rules_changed), .upd_mask(upd_mask)
);

// File: tb/test_pmp_cfg_regfile.sv
module test_pmp_cfg_regfile;
  localparam int N  = 16;
  localparam int XL = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ext_en, wr_en;
  logic [1:0] wr_sel, rd_sel;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [XL-1:0] wr_data, rd_data;
  logic [N*8-1:0] cfg_out;
  logic [N*XL-1:0] addr_out;
  logic [2:0] sec_out;
  logic rules_changed;
  logic [N-1:0] upd_mask;

  pmp_cfg_regfile #(.N_ENT(N), .XLEN(XL), .IDX_W(IW)) i_pmp_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .rd_data(rd_data), .cfg_out(cfg_out), .addr_out(addr_out), .sec_out(sec_out),
    .rules_changed(rules_changed), .upd_mask(upd_mask)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic chg; logic [N-1:0] mask; string tag; } exp_t;
  exp_t q[$];

  logic [7:0]    m_cfg [N];
  logic [XL-1:0] m_addr[N];
  logic [2:0]    m_sec;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int idx, input logic [XL-1:0] d, input string tag);
    exp_t x;
    logic [N:0] mk;
    logic c;
    logic [2:0] ns;
    mk = '0;
    c  = 1'b0;
    if (sel == 2'd0) begin
      for (int e = 0; e < N; e++)
        if (e / 4 == idx && !m_cfg[e][7] && d[(e%4)*8 +: 8] != m_cfg[e]) begin
          m_cfg[e] = d[(e%4)*8 +: 8];
          mk[e] = 1'b1;
        end
    end else if (sel == 2'd1) begin
      if (idx < N) begin
        bit nx_tor, nx_lk;
        nx_tor = (idx + 1 < N) ? (m_cfg[idx+1][4:3] == 2'd1) : 1'b0;
        nx_lk  = (idx + 1 < N) ? m_cfg[idx+1][7] : 1'b0;
        if (!m_cfg[idx][7] && !(nx_tor && nx_lk) && d != m_addr[idx]) begin
          m_addr[idx] = d;
          mk[idx] = 1'b1;
          if (nx_tor) mk[idx+1] = 1'b1;
        end
      end
    end else if (sel == 2'd2) begin
      if (ext_en) begin
        ns = {d[2], d[1:0] | m_sec[1:0]};
        c = (ns[1:0] != m_sec[1:0]);
        m_sec = ns;
      end else begin
        m_sec = '0;
      end
    end
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    x.due = cyc + 1; x.chg = c | (|mk); x.mask = mk[N-1:0]; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [XL-1:0] mrd(input logic [1:0] sel, input int idx);
    logic [XL-1:0] r = '0;
    if (sel == 2'd0) begin
      for (int b = 0; b < 4; b++) if (idx*4 + b < N) r[b*8 +: 8] = m_cfg[idx*4 + b];
    end else if (sel == 2'd1) begin
      if (idx < N) r = m_addr[idx];
    end else if (sel == 2'd2) r[2:0] = m_sec;
    return r;
  endfunction

  task automatic rd(input logic [1:0] sel, input int idx, input logic [XL-1:0] exp, input string tag);
    @(negedge clk);
    rd_sel = sel; rd_idx = IW'(idx);
    #1;
    check(rd_data === exp, tag, 64'(rd_data), 64'(exp));
  endtask

  always @(negedge clk) begin : monitor
    exp_t x;
    if (q.size() > 0 && q[0].due == cyc) begin
      x = q.pop_front();
      check(rules_changed === x.chg, {x.tag, " R5 pulse"}, 64'(rules_changed), 64'(x.chg));
      check(upd_mask === x.mask, {x.tag, " R5 mask"}, 64'(upd_mask), 64'(x.mask));
    end else if (rst_n && !done) begin
      check(rules_changed === 1'b0, "R5 idle pulse", 64'(rules_changed), 64'd0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    m_sec = '0;
    rst_n = 0; ext_en = 1; wr_en = 0; wr_sel = 0; wr_idx = 0; wr_data = 0; rd_sel = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    check(rules_changed === 1'b0, "R1 pulse", 64'(rules_changed), 64'd0);
    check(upd_mask === '0, "R1 mask", 64'(upd_mask), 64'd0);
    check(cfg_out === '0, "R1 cfg", 64'(cfg_out[63:0]), 64'd0);
    check(addr_out === '0 && sec_out === '0, "R1 addr/sec", 64'(sec_out), 64'd0);
    rst_n = 1;
    rd(2'd0, 3, 32'h0, "R1 cfg read");

    wr(2'd0, 0, 32'h0F0B0901, "R2 cfg write");
    rd(2'd0, 0, 32'h0F0B0901, "R2 cfg readback");
    wr(2'd0, 0, 32'h0F0B0901, "R4 equal cfg");
    wr(2'd0, 0, 32'h0F0B0905, "R4 one byte");
    wr(2'd1, 5, 32'h1000, "R8 addr write");
    rd(2'd1, 5, 32'h1000, "R8 addr readback");
    wr(2'd0, 1, 32'h00080000, "R2 entry6 TOR");
    wr(2'd1, 5, 32'h2000, "R8 TOR neighbour");
    wr(2'd1, 5, 32'h2000, "R8 equal addr");
    wr(2'd0, 1, 32'h00880000, "R3 lock entry6");
    wr(2'd1, 5, 32'h3000, "R7 refused");
    rd(2'd1, 5, 32'h2000, "R7 addr unchanged");
    wr(2'd1, 6, 32'h4000, "R6 refused");
    rd(2'd1, 6, 32'h0, "R6 addr unchanged");
    wr(2'd0, 1, 32'h0, "R3 locked byte");
    rd(2'd0, 1, 32'h00880000, "R3 cfg unchanged");
    wr(2'd0, 0, 32'h0F8B0905, "R3 lock entry2");
    wr(2'd0, 0, 32'h1F000907, "R3 mixed write");
    rd(2'd0, 0, 32'h1F8B0907, "R3 mixed readback");
    wr(2'd1, 2, 32'h77, "R6 entry2 locked");
    wr(2'd1, 15, 32'hABCD, "R8 last entry");
    wr(2'd0, 4, 32'hFFFFFFFF, "R2 out of range");
    rd(2'd0, 4, 32'h0, "R11 missing cfg");
    wr(2'd1, 16, 32'h55, "R8 out of range");
    rd(2'd1, 16, 32'h0, "R11 missing addr");

    wr(2'd2, 0, 32'h3, "R9 set sticky");
    rd(2'd2, 0, 32'h3, "R9 readback");
    wr(2'd2, 0, 32'h0, "R9 clear attempt");
    rd(2'd2, 0, 32'h3, "R9 still set");
    wr(2'd2, 0, 32'h4, "R9 third bit only");
    rd(2'd2, 0, 32'h7, "R9 third bit");
    ext_en = 0;
    wr(2'd2, 0, 32'h7, "R10 forced zero");
    rd(2'd2, 0, 32'h0, "R10 readback");
    ext_en = 1;
    wr(2'd2, 0, 32'h2, "R9 set bit1");
    rd(2'd2, 0, 32'h2, "R9 bit1 readback");
    rd(2'd3, 0, 32'h0, "R11 unused select");

    for (int i = 0; i < N/4; i++) rd(2'd0, i, mrd(2'd0, i), "R11 cfg sweep");
    for (int i = 0; i < N; i++) rd(2'd1, i, mrd(2'd1, i), "R11 addr sweep");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule